// File: doc/BRIEF.md
# Audio Receive FIFO With Channel Conversion

This block sits between an upstream PCM word stream and a downstream consumer that works on whole frames. Each incoming word is converted to a 24-bit sample as it arrives and is stored in a 64-word buffer. The consumer asks for frames one at a time. On each request the block removes one frame from the buffer and turns it into a left/right pair that matches the client's channel count. A mono stream can be widened to stereo. A stereo stream can be narrowed to mono by picking one channel or by averaging both.

Output starts only once enough frames are stored. The fill threshold is given in frames. It is clamped so that it can never ask for more frames than the buffer holds. Two sticky flags record when a word was dropped because the buffer was full, and when a frame was requested but none was available.

Top module: `rx_audio_fifo`

## Requirements
- R1: The buffer holds 64 words. A word that arrives while 64 words are stored is discarded and sets `ovf_flag`, which stays set until reset.
- R2: With `cfg_wide`=0 a word becomes {in_data[15:0], 8'h00}. With `cfg_wide`=1 it becomes in_data[31:8].
- R3: After reset, and after the buffer has been seen with zero complete frames, no frame is delivered until the stored frame count is greater than the effective threshold. The effective threshold is `cfg_thresh` limited to 63 for a mono stream and to 31 for a stereo stream.
- R4: While running, each `out_req` with at least one complete frame stored removes exactly one frame (1 word for a mono stream, 2 words for a stereo stream, oldest first). The result appears with `out_valid`=1 on the cycle after the request. When running and zero frames are seen, the block returns to stalled.
- R5: With a stereo stream (`cfg_stream_stereo`=1) and a stereo client (`cfg_client_stereo`=1), `out_left` is the first word of the frame and `out_right` is the second.
- R6: With a mono stream and a stereo client, `out_left` is the sample. `out_right` is zero when `cfg_m2s_copy`=0 and is a copy of the sample when it is 1.
- R7: With a stereo stream and a mono client, `out_right` is zero. `out_left` depends on `cfg_s2m_sel`: code 0 gives the first word, code 1 gives the second word, and codes 2 and 3 give floor((a+b)/2), computed at 25 bits so that it never overflows.
- R8: With a mono stream and a mono client, `out_left` is the sample and `out_right` is zero.
- R9: Once output has started after reset, an `out_req` seen while no complete frame is stored sets `unf_flag`, which stays set until reset. That request produces no `out_valid`.
- R10: While `rst_n` is low, `out_valid`, `ovf_flag` and `unf_flag` are 0, and the buffer is emptied.
- R11: A request made while stalled produces no `out_valid` and removes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | Input width: 0 = 16-bit, 1 = 32-bit |
| cfg_stream_stereo | input | 1 | Stream channel count: 0 = 1, 1 = 2 |
| cfg_client_stereo | input | 1 | Client channel count: 0 = 1, 1 = 2 |
| cfg_m2s_copy | input | 1 | Mono widening: 0 = zero-fill, 1 = copy |
| cfg_s2m_sel | input | 2 | Stereo narrowing: 0 = first, 1 = second, 2/3 = average |
| cfg_thresh | input | 6 | Start threshold in frames |
| in_valid | input | 1 | Upstream word strobe |
| in_data | input | 32 | Upstream PCM word |
| out_req | input | 1 | Consumer frame request |
| out_valid | output | 1 | Frame delivered this cycle |
| out_left | output | 24 | Left / mono sample |
| out_right | output | 24 | Right sample |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The assertions check the following on every cycle:
- The buffer occupancy stays within its bounds.
- No word is written into a full buffer, and no read goes past the stored words.
- Both flags stay set once raised.
- Every delivered frame follows a request.
- Running starts only above the effective threshold.
- The right channel is zero whenever the client is mono.

Only the bench scenarios can show that the right data comes out in the right order. Those scenarios cover: each channel-mapping and width combination, the clamping of the threshold at its exact boundary, the discarding of words at full capacity, and the rounding of the average for extreme signed pairs.

// File: rtl/rx_afifo_pkg.sv
// Shared constants and codes for the audio receive FIFO.
package rx_afifo_pkg;
    localparam int SAMPLE_W = 24;
    localparam int WORD_W   = 32;
    localparam int NARROW_W = 16;

    // Stereo-to-mono selection codes (3 also averages)
    localparam logic [1:0] S2M_FIRST  = 2'd0;
    localparam logic [1:0] S2M_SECOND = 2'd1;
endpackage

// File: rtl/rx_afifo_fmt.sv
// Width converter: maps a 16- or 32-bit signed input word onto a
// fixed-width sample. Assumes OUT_W >= NARROW_W and IN_W >= OUT_W.
module rx_afifo_fmt #(
    parameter int IN_W     = 32,
    parameter int OUT_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic              wide,
    input  logic [IN_W-1:0]   din,
    output logic [OUT_W-1:0]  dout
);
    localparam int PAD_W = OUT_W - NARROW_W;

    // Left-justify narrow words, keep the top bits of wide words
    always_comb begin
        if (wide)
            dout = din[IN_W-1 -: OUT_W];
        else
            dout = {din[NARROW_W-1:0], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/rx_afifo_store.sv
// Circular word buffer with a single push and a pop of one or two words.
// Shows the two oldest words at the same time so that a whole stereo frame
// can leave in one cycle. Assumes DEPTH is a power of two and that the
// caller never pushes when full or pops more than is stored.
module rx_afifo_store #(
    parameter int DEPTH = 64,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          pop_two,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [1:0]    pop_n;

    assign pop_n = pop ? (pop_two ? 2'd2 : 2'd1) : 2'd0;
    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push) - CW'(pop_n);
        end
    end

    AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CW'(DEPTH)); // R1
    AST_NO_POP_PAST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count >= CW'(pop_n)); // R4
endmodule

// File: rtl/rx_afifo_map.sv
// Frame mapper: turns one stored frame (one or two words) into a
// left/right pair for the client, applying mono widening or stereo
// narrowing. Purely combinational.
module rx_afifo_map
    import rx_afifo_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         stream_stereo,
    input  logic         client_stereo,
    input  logic         m2s_copy,
    input  logic [1:0]   s2m_sel,
    input  logic [W-1:0] w0,
    input  logic [W-1:0] w1,
    output logic [W-1:0] left,
    output logic [W-1:0] right
);
    logic [W:0] sum;

    // Channel routing and sign-extended average
    always_comb begin
        sum   = {w0[W-1], w0} + {w1[W-1], w1};
        left  = w0;
        right = '0;
        if (stream_stereo) begin
            if (client_stereo) begin
                right = w1;
            end else begin
                case (s2m_sel)
                    S2M_FIRST:  left = w0;
                    S2M_SECOND: left = w1;
                    default:    left = sum[W:1];
                endcase
            end
        end else if (client_stereo && m2s_copy) begin
            right = w0;
        end
    end
endmodule

// File: rtl/rx_audio_fifo.sv
// Audio receive FIFO with channel conversion.
// Converts each incoming word to a 24-bit sample and buffers it. It holds
// output back until the stored frames exceed a clamped threshold, then
// hands out one frame per consumer request, one cycle later. Assumes the
// configuration inputs are steady while a stream is active.
module rx_audio_fifo
    import rx_afifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wide,
    input  logic                cfg_stream_stereo,
    input  logic                cfg_client_stereo,
    input  logic                cfg_m2s_copy,
    input  logic [1:0]          cfg_s2m_sel,
    input  logic [AW-1:0]       cfg_thresh,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                out_req,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                ovf_flag,
    output logic                unf_flag
);
    localparam logic [CW-1:0] MAX_TH_MONO   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] MAX_TH_STEREO = CW'(DEPTH / 2 - 1);

    logic [SAMPLE_W-1:0] conv_word;
    logic [SAMPLE_W-1:0] head0, head1;
    logic [SAMPLE_W-1:0] map_left, map_right;
    logic [CW-1:0]       count;
    logic [CW-1:0]       frames;
    logic [CW-1:0]       max_th;
    logic [CW-1:0]       eff_th;
    logic                full;
    logic                push;
    logic                do_pop;
    logic                running;
    logic                primed;

    rx_afifo_fmt #(.IN_W(WORD_W), .OUT_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_fmt (
        .wide (cfg_wide),
        .din  (in_data),
        .dout (conv_word)
    );

    rx_afifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (conv_word),
        .pop       (do_pop),
        .pop_two   (cfg_stream_stereo),
        .head0     (head0),
        .head1     (head1),
        .count     (count)
    );

    rx_afifo_map #(.W(SAMPLE_W)) u_map (
        .stream_stereo (cfg_stream_stereo),
        .client_stereo (cfg_client_stereo),
        .m2s_copy      (cfg_m2s_copy),
        .s2m_sel       (cfg_s2m_sel),
        .w0            (head0),
        .w1            (head1),
        .left          (map_left),
        .right         (map_right)
    );

    // Frame count, threshold clamp and pop qualification
    always_comb begin
        frames = cfg_stream_stereo ? (count >> 1) : count;
        max_th = cfg_stream_stereo ? MAX_TH_STEREO : MAX_TH_MONO;
        eff_th = (CW'(cfg_thresh) > max_th) ? max_th : CW'(cfg_thresh);
        full   = (count == CW'(DEPTH));
        push   = in_valid && !full;
        do_pop = out_req && running && (frames != '0);
    end

    // Run/stall control, sticky flags and registered frame output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            primed    <= 1'b0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            if (!running && frames > eff_th) begin
                running <= 1'b1;
                primed  <= 1'b1;
            end else if (running && frames == '0) begin
                running <= 1'b0;
            end
            if (in_valid && full)
                ovf_flag <= 1'b1;
            if (out_req && primed && frames == '0)
                unf_flag <= 1'b1;
            out_valid <= do_pop;
            if (do_pop) begin
                out_left  <= map_left;
                out_right <= map_right;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R1
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag); // R9
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_req)); // R4
    AST_START_ABOVE_TH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(frames > eff_th)); // R3
    AST_MONO_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cfg_client_stereo)) |-> out_right == '0); // R7
endmodule

// File: tb/tb_rx_audio_fifo.sv
`timescale 1ns/1ps
module tb_rx_audio_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide, cfg_stream_stereo, cfg_client_stereo, cfg_m2s_copy;
    logic [1:0]  cfg_s2m_sel;
    logic [5:0]  cfg_thresh;
    logic        in_valid;
    logic [31:0] in_data;
    logic        out_req;
    logic        out_valid;
    logic [23:0] out_left, out_right;
    logic        ovf_flag, unf_flag;

    int checks = 0;
    int fails  = 0;

    logic [23:0] q[$];
    bit m_run, m_primed, m_ovf, m_unf;

    always #4 clk = ~clk;

    rx_audio_fifo dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .cfg_stream_stereo(cfg_stream_stereo), .cfg_client_stereo(cfg_client_stereo),
        .cfg_m2s_copy(cfg_m2s_copy), .cfg_s2m_sel(cfg_s2m_sel), .cfg_thresh(cfg_thresh),
        .in_valid(in_valid), .in_data(in_data), .out_req(out_req),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic logic [23:0] conv(logic [31:0] d, logic wide);
        return wide ? d[31:8] : {d[15:0], 8'h00};
    endfunction

    function automatic logic [23:0] avg24(logic [23:0] a, logic [23:0] b);
        logic signed [24:0] s;
        s = $signed({a[23], a}) + $signed({b[23], b});
        return 24'(s >>> 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_req = 1'b0; in_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 ovf", 32'(ovf_flag), 0);
        chk("R10 unf", 32'(unf_flag), 0);
        rst_n = 1'b1;
        q.delete(); m_run = 0; m_primed = 0; m_ovf = 0; m_unf = 0;
    endtask

    // One cycle: drive, predict from the model, clock, compare
    task automatic step(bit push, logic [31:0] d, bit req, string vtag);
        int cnt, frames, mx, eth;
        bit ev, nrun;
        logic [23:0] w0, w1, el, er;
        string dtag;
        in_valid = push; in_data = d; out_req = req;
        cnt    = q.size();
        frames = cfg_stream_stereo ? cnt / 2 : cnt;
        mx     = cfg_stream_stereo ? 31 : 63;
        eth    = (int'(cfg_thresh) > mx) ? mx : int'(cfg_thresh);
        ev     = m_run && frames > 0 && req;
        el = '0; er = '0; dtag = "";
        if (ev) begin
            w0 = q[0];
            w1 = cfg_stream_stereo ? q[1] : 24'h0;
            if (cfg_stream_stereo && cfg_client_stereo) begin
                el = w0; er = w1; dtag = "R5";
            end else if (cfg_stream_stereo) begin
                el = (cfg_s2m_sel == 2'd0) ? w0 : (cfg_s2m_sel == 2'd1) ? w1 : avg24(w0, w1);
                dtag = "R7";
            end else if (cfg_client_stereo) begin
                el = w0; er = cfg_m2s_copy ? w0 : 24'h0; dtag = "R6";
            end else begin
                el = w0; dtag = "R8";
            end
        end
        nrun = m_run;
        if (!m_run && frames > eth) begin nrun = 1; m_primed = 1; end
        else if (m_run && frames == 0) nrun = 0;
        if (req && m_primed && frames == 0 && !(!m_run && frames > eth)) m_unf = 1;
        if (push && cnt == 64) m_ovf = 1;
        if (ev) begin
            void'(q.pop_front());
            if (cfg_stream_stereo) void'(q.pop_front());
        end
        if (push && cnt < 64) q.push_back(conv(d, cfg_wide));
        m_run = nrun;
        @(posedge clk);
        #1;
        chk(vtag, 32'(out_valid), 32'(ev));
        if (ev) begin
            chk({dtag, " left"}, 32'(out_left), 32'(el));
            chk({dtag, " right"}, 32'(out_right), 32'(er));
        end
        chk("R1 ovf", 32'(ovf_flag), 32'(m_ovf));
        chk("R9 unf", 32'(unf_flag), 32'(m_unf));
        in_valid = 1'b0; out_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        cfg_wide = 0; cfg_stream_stereo = 1; cfg_client_stereo = 1;
        cfg_m2s_copy = 0; cfg_s2m_sel = 0; cfg_thresh = 6'd3;
        do_reset();

        // 16-bit stereo pass-through, threshold 3 frames
        for (int i = 0; i < 6; i++) step(1, $urandom, 0, "R3");
        step(0, 0, 1, "R11");
        step(0, 0, 1, "R11");
        step(0, 0, 1, "R3");
        for (int i = 0; i < 2; i++) step(1, $urandom, 0, "R3");
        step(0, 0, 0, "R4");
        for (int i = 0; i < 300; i++)
            step($urandom_range(1, 0) == 1, $urandom, $urandom_range(9, 0) < 4, "R4");
        for (int i = 0; i < 50; i++) step(0, 0, 1, "R4");
        chk("R9 final", 32'(unf_flag), 1);

        // 32-bit stereo stream to mono client, threshold clamped to 31
        cfg_wide = 1; cfg_client_stereo = 0; cfg_thresh = 6'd63; cfg_s2m_sel = 2'd2;
        do_reset();
        step(1, 32'h7FFFFF00, 0, "R3"); step(1, 32'h7FFFFF00, 0, "R3");
        step(1, 32'h80000000, 0, "R3"); step(1, 32'h80000000, 0, "R3");
        step(1, 32'hFFFFFF00, 0, "R3"); step(1, 32'h00000100, 0, "R3");
        step(1, 32'hFFFFFF00, 0, "R3"); step(1, 32'hFFFFFE00, 0, "R3");
        for (int i = 0; i < 54; i++) step(1, $urandom, 0, "R3");
        step(0, 0, 1, "R3");
        step(0, 0, 1, "R3");
        for (int i = 0; i < 10; i++) step(1, $urandom, 0, "R1");
        chk("R1 full", 32'(ovf_flag), 1);
        for (int i = 0; i < 4; i++) step(0, 0, 1, "R7");
        for (int i = 0; i < 40; i++) begin
            cfg_s2m_sel = 2'(i % 4);
            step(0, 0, 1, "R4");
        end
        for (int i = 0; i < 200; i++) begin
            cfg_s2m_sel = 2'($urandom_range(3, 0));
            step($urandom_range(1, 0) == 1, $urandom, $urandom_range(9, 0) < 4, "R4");
        end

        // 16-bit mono stream, threshold 0, stereo then mono client
        cfg_wide = 0; cfg_stream_stereo = 0; cfg_client_stereo = 1; cfg_thresh = 6'd0;
        do_reset();
        step(1, 32'h00008001, 0, "R2");
        step(0, 0, 0, "R2");
        cfg_client_stereo = 0;
        step(0, 0, 1, "R2");
        chk("R2 narrow", 32'(out_left), 32'h00800100);
        cfg_client_stereo = 1;
        for (int i = 0; i < 200; i++) begin
            cfg_m2s_copy = $urandom_range(1, 0) == 1;
            step($urandom_range(1, 0) == 1, $urandom, $urandom_range(9, 0) < 5, "R6");
        end
        cfg_client_stereo = 0;
        for (int i = 0; i < 150; i++)
            step($urandom_range(1, 0) == 1, $urandom, $urandom_range(9, 0) < 5, "R8");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule